// File: doc/BRIEF.md
# Receive DMA Write Engine

This block drains received frames from a receive FIFO into host memory. A descriptor fetch engine hands it the address of a descriptor that is ready to be filled. The engine reads the descriptor's control word and its two buffer addresses over a shared host bus. It then writes the frame into the first buffer and, when the descriptor allows, into the second, in bursts no longer than a configured limit. It waits between bursts for FIFO data and bus grant, picks up the status word that trails each frame in the FIFO, and writes the completed descriptor word back with the ownership bit cleared.

If the frame is longer than the descriptor can hold, the descriptor is closed without status and the frame continues in the next descriptor the fetch engine offers. If no descriptor is available, the FIFO contents are thrown away, and each discarded start-of-frame word raises a pulse for a missed-frame counter kept elsewhere.

Top module: `rx_dma_writer`

## Requirements
- R1: After reset the block issues no bus command (`m_cmd` = 0), does not read the FIFO, and holds `ds_done` and `miss_inc` low.
- R2: With a descriptor valid, data in the FIFO and the bus granted, the block reads three words using command 2 (read), at descriptor address +4, +8 and +12. `m_last` is set on the third word only. Word +4 holds buffer-1 size in bytes in bits 10:0, buffer-2 size in bytes in bits 21:11, and a chain flag in bit 24. Word +8 holds the buffer-1 address and word +12 the buffer-2 address. Sizes are multiples of 4.
- R3: Frame words are written using command 1 (write) to consecutive word addresses starting at the buffer address. Each burst holds the smaller of the limit, the words left in the buffer and the words left in the frame. A limit of 0 means 64. `m_last` marks the final word of each burst.
- R4: Between bursts, the block goes back to idle without any bus command if the descriptor-valid input is low.
- R5: When buffer 1 fills before the frame ends, writing continues at the buffer-2 address if the chain flag is clear and the buffer-2 size is nonzero. Otherwise the block writes `{1'b0, err, 30'b0}` to the descriptor address and continues the frame in the next descriptor.
- R6: A burst also ends on a word taken while the FIFO flags almost-empty (exactly one entry).
- R7: The FIFO word after the end-of-frame word is the status. The block writes `{1'b0, err, 1'b1, status[28:0]}` to the descriptor address, where `err` also includes status bit 16. `ds_done` pulses in the cycle this write is accepted.
- R8: With no valid descriptor, the block reads and discards FIFO words, and `miss_inc` pulses once for each discarded word flagged start-of-frame.
- R9: The error bit (bit 30) of a writeback is set when a bus error was returned, or a FIFO word flagged error was written, while that descriptor was in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | Host bus may be claimed for a new transfer |
| ds_valid | input | 1 | A descriptor is ready at `ds_addr` |
| ds_addr | input | 32 | Address of the current descriptor |
| burst_limit | input | BLW | Maximum words per data burst, 0 means 64 |
| ds_done | output | 1 | Descriptor writeback accepted |
| miss_inc | output | 1 | Frame discarded for lack of a descriptor |
| fifo_rd | output | 1 | Pop the FIFO head |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_aempty | input | 1 | FIFO holds exactly one entry |
| fifo_data | input | 32 | FIFO head word |
| fifo_sof | input | 1 | Head word starts a frame |
| fifo_eof | input | 1 | Head word ends a frame |
| fifo_err | input | 1 | Head word carries a receive error |
| m_cmd | output | 2 | Bus command: 0 none, 1 write, 2 read |
| m_addr | output | 32 | Bus byte address |
| m_wdata | output | 32 | Bus write data |
| m_last | output | 1 | Final word of the current transfer |
| s_rdata | input | 32 | Bus read data |
| s_valid | input | 1 | Current word accepted or returned |
| s_err | input | 1 | Bus error on the current word |

## Verification
Every bus word, FIFO pop and pulse is combinational on the block's state. A word takes effect in the same cycle `s_valid` is high, and the state it changes is visible from the next clock. The bench therefore drives FIFO, grant and descriptor inputs just after the falling edge and drives the slave reply 1 ns later. It compares address, data, `m_last`, `ds_done` and `miss_inc` against its own model 2 ns after that, still before the rising edge that commits the word. Ends of bursts are predicted from the limit, the buffer fill and the frame fill at the first word of each burst. A limit or descriptor-valid change takes effect one cycle after the bench applies it.

// File: rtl/rx_dma_writer.sv
module rx_dma_writer #(
  parameter int BLW = 6,
  parameter int SZW = 11,
  parameter int CHAIN_BIT = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grant,
  input  logic           ds_valid,
  input  logic [31:0]    ds_addr,
  input  logic [BLW-1:0] burst_limit,
  output logic           ds_done,
  output logic           miss_inc,
  output logic           fifo_rd,
  input  logic           fifo_empty,
  input  logic           fifo_aempty,
  input  logic [31:0]    fifo_data,
  input  logic           fifo_sof,
  input  logic           fifo_eof,
  input  logic           fifo_err,
  output logic [1:0]     m_cmd,
  output logic [31:0]    m_addr,
  output logic [31:0]    m_wdata,
  output logic           m_last,
  input  logic [31:0]    s_rdata,
  input  logic           s_valid,
  input  logic           s_err
);
  localparam int WW = SZW - 2;

  typedef enum logic [2:0] {S_IDLE, S_RDDS, S_PAUSE, S_WR, S_STAT, S_WBDS} st_t;

  st_t            st;
  logic [1:0]     rcnt;
  logic           chain, second, final_seg, err_seen;
  logic [WW-1:0]  sz1, sz2, left;
  logic [31:0]    b1, b2, addr, stat;
  logic [BLW-1:0] bcnt;

  wire use2      = !second && !chain && (sz2 != '0);
  wire burst_end = fifo_eof || fifo_aempty || (left == WW'(1)) ||
                   (BLW'(bcnt + 1'b1) == burst_limit);
  wire discard   = (st == S_IDLE) && !ds_valid && !fifo_empty;
  wire [31:0] wb = final_seg ? {1'b0, stat[16] | err_seen, 1'b1, stat[28:0]}
                             : {1'b0, err_seen, 30'b0};

  assign miss_inc = discard && fifo_sof;
  assign ds_done  = (st == S_WBDS) && s_valid;
  assign fifo_rd  = discard || ((st == S_WR) && s_valid) ||
                    ((st == S_STAT) && !fifo_empty);

  always_comb begin
    m_cmd = 2'd0; m_addr = '0; m_wdata = '0; m_last = 1'b0;
    case (st)
      S_RDDS: begin
        m_cmd  = 2'd2;
        m_addr = ds_addr + 32'({rcnt + 2'd1, 2'b00});
        m_last = (rcnt == 2'd2);
      end
      S_WR: begin
        m_cmd = 2'd1; m_addr = addr; m_wdata = fifo_data; m_last = burst_end;
      end
      S_WBDS: begin
        m_cmd = 2'd1; m_addr = ds_addr; m_wdata = wb; m_last = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rcnt <= '0; chain <= 1'b0; second <= 1'b0;
      final_seg <= 1'b0; err_seen <= 1'b0; sz1 <= '0; sz2 <= '0;
      left <= '0; b1 <= '0; b2 <= '0; addr <= '0; stat <= '0; bcnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (ds_valid && !fifo_empty && grant) begin
            st <= S_RDDS; rcnt <= '0; err_seen <= 1'b0;
          end
        S_RDDS:
          if (s_valid) begin
            err_seen <= err_seen | s_err;
            rcnt <= rcnt + 2'd1;
            case (rcnt)
              2'd0: begin
                sz1   <= s_rdata[SZW-1:2];
                sz2   <= s_rdata[2*SZW-1:SZW+2];
                chain <= s_rdata[CHAIN_BIT];
              end
              2'd1: b1 <= s_rdata;
              default: begin
                b2 <= s_rdata; addr <= b1; left <= sz1; second <= 1'b0;
                st <= S_PAUSE;
              end
            endcase
          end
        S_PAUSE:
          if (!ds_valid) st <= S_IDLE;
          else if (!fifo_empty && grant) begin
            st <= S_WR; bcnt <= '0;
          end
        S_WR:
          if (s_valid) begin
            err_seen <= err_seen | s_err | fifo_err;
            addr <= addr + 32'd4;
            left <= left - WW'(1);
            bcnt <= bcnt + 1'b1;
            if (burst_end) begin
              if (fifo_eof) st <= S_STAT;
              else if (left == WW'(1)) begin
                if (use2) begin
                  second <= 1'b1; addr <= b2; left <= sz2; st <= S_PAUSE;
                end else begin
                  final_seg <= 1'b0; st <= S_WBDS;
                end
              end else st <= S_PAUSE;
            end
          end
        S_STAT:
          if (!fifo_empty) begin
            stat <= fifo_data; final_seg <= 1'b1; st <= S_WBDS;
          end
        S_WBDS:
          if (s_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_rd_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_inc |-> (m_cmd == 2'd0) && fifo_rd);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ds_done |=> (m_cmd == 2'd0));
  p_pause_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE && !ds_valid) |=> (st == S_IDLE));
  p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && s_valid && burst_limit != '0) |-> (bcnt < burst_limit));
  p_rd_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDDS && s_valid && m_last) |=> (st == S_PAUSE));
  p_aempty_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && fifo_aempty) |-> m_last);
endmodule

// File: tb/sim_rx_dma_writer.sv
module sim_rx_dma_writer;
  logic clk = 0, rst_n = 0, grant = 0, ds_valid = 0;
  logic [31:0] ds_addr = 0;
  logic [5:0] burst_limit = 0;
  logic ds_done, miss_inc, fifo_rd, m_last;
  logic fifo_empty = 1, fifo_aempty = 0, fifo_sof = 0, fifo_eof = 0, fifo_err = 0;
  logic [31:0] fifo_data = 0, s_rdata = 0, m_addr, m_wdata;
  logic [1:0] m_cmd;
  logic s_valid = 0, s_err = 0;

  rx_dma_writer u0 (.clk(clk), .rst_n(rst_n), .grant(grant), .ds_valid(ds_valid),
    .ds_addr(ds_addr), .burst_limit(burst_limit), .ds_done(ds_done), .miss_inc(miss_inc),
    .fifo_rd(fifo_rd), .fifo_empty(fifo_empty), .fifo_aempty(fifo_aempty),
    .fifo_data(fifo_data), .fifo_sof(fifo_sof), .fifo_eof(fifo_eof), .fifo_err(fifo_err),
    .m_cmd(m_cmd), .m_addr(m_addr), .m_wdata(m_wdata), .m_last(m_last),
    .s_rdata(s_rdata), .s_valid(s_valid), .s_err(s_err));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [1024];
  logic [34:0] q [$];
  int cyc = 0, miss_n = 0, cmd_n = 0, data_n = 0, wb_n = 0;
  int didx = 0, ndesc = 1, rk = 0, bc = 0, eb = 0, bl = 0, bno = 0, fl = 0, di = 0;
  int s1w = 0, s2w = 0, lim_eff = 1, fid = 0;
  bit nv = 0, use2 = 0, drop = 0, err_once = 0, desc_err = 0, cur_ferr = 0;
  bit chk_burst = 1, trickle = 0;
  logic [31:0] ea = 0, cur_sw = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dadr(int k); return 32'h40 + 32'(16 * k); endfunction
  function automatic logic [31:0] b1a(int k); return 32'h400 + 32'(k * 32'h200); endfunction
  function automatic logic [31:0] wd(int f, int i); return 32'hA000_0000 | (32'(f) << 12) | 32'(i); endfunction

  task automatic cycle();
    logic [31:0] exp;
    @(negedge clk);
    cyc++;
    ds_valid = nv;
    ds_addr = dadr(didx);
    grant = (cyc % 7) != 0;
    fifo_empty = (q.size() == 0);
    fifo_aempty = (q.size() == 1);
    if (q.size() > 0) {fifo_err, fifo_sof, fifo_eof, fifo_data} = q[0];
    else {fifo_err, fifo_sof, fifo_eof, fifo_data} = '0;
    #1;
    s_valid = (m_cmd != 2'd0) && (cyc % 5 != 3);
    s_rdata = (m_cmd == 2'd2) ? mem[m_addr[11:2]] : 32'h0;
    s_err = s_valid && err_once && m_cmd == 2'd1 && m_addr >= 32'h400;
    #1;
    if (m_cmd != 2'd0) cmd_n++;
    if (miss_inc) miss_n++;
    if (s_err) begin err_once = 0; desc_err = 1; end
    if (s_valid && m_cmd == 2'd2) begin
      chk(m_addr == dadr(didx) + 32'(4 * (rk + 1)), "R2 read address", m_addr, dadr(didx) + 32'(4 * (rk + 1)));
      chk(m_last == (rk == 2), "R2 read last", 32'(m_last), 32'(rk == 2));
      if (rk == 0) desc_err = 0;
      if (rk == 2) begin
        rk = 0; bl = s1w; bno = 0; ea = b1a(didx); bc = 0;
        if (drop) nv = 0;
      end else rk++;
    end
    if (s_valid && m_cmd == 2'd1 && m_addr >= 32'h400) begin
      if (bc == 0) begin
        eb = lim_eff;
        if (bl < eb) eb = bl;
        if (fl < eb) eb = fl;
      end
      bc++;
      if (chk_burst) chk(m_last == (bc == eb), "R3 burst end", 32'(bc), 32'(eb));
      if (trickle) chk(m_last, "R6 almost-empty burst end", 32'(m_last), 32'd1);
      if (m_last) bc = 0;
      chk(m_addr == ea, "R3/R5 write address", m_addr, ea);
      chk(m_wdata == wd(fid, di), "R3 write data", m_wdata, wd(fid, di));
      if (fifo_err) desc_err = 1;
      di++; fl--; bl--; ea += 4; data_n++;
      if (bl == 0 && fl != 0 && bno == 0 && use2) begin
        bl = s2w; bno = 1; ea = b1a(didx) + 32'h100;
      end
    end
    if (s_valid && m_cmd == 2'd1 && m_addr < 32'h400) begin
      chk(m_addr == dadr(didx), "R7 writeback address", m_addr, dadr(didx));
      if (fl == 0) exp = {1'b0, desc_err | cur_ferr, 1'b1, cur_sw[28:0]};
      else exp = {1'b0, desc_err, 30'b0};
      chk(m_wdata == exp, (fl == 0) ? ((desc_err | cur_ferr) ? "R9 error summary" : "R7 final writeback")
                                    : "R5 spill writeback", m_wdata, exp);
      chk(ds_done, "R7 done pulse", 32'(ds_done), 32'd1);
      wb_n++; didx++;
      nv = (didx < ndesc);
    end
    if (fifo_rd) void'(q.pop_front());
  endtask

  task automatic setup(int cfg, int lim, int len, int f, bit fe);
    logic [31:0] ctl;
    bit chain;
    case (cfg)
      0: begin s1w = 3; s2w = 20; chain = 0; end
      1: begin s1w = 16; s2w = 8; chain = 1; end
      default: begin s1w = 4; s2w = 0; chain = 0; end
    endcase
    use2 = !chain && s2w != 0;
    ctl = (32'(chain) << 24) | (32'(s2w * 4) << 11) | 32'(s1w * 4);
    for (int k = 0; k < 3; k++) begin
      mem[dadr(k)[11:2] + 1] = ctl;
      mem[dadr(k)[11:2] + 2] = b1a(k);
      mem[dadr(k)[11:2] + 3] = b1a(k) + 32'h100;
    end
    ndesc = (cfg == 2) ? (len + 3) / 4 : 1;
    burst_limit = 6'(lim);
    lim_eff = (lim == 0) ? 64 : lim;
    fl = len; di = 0; bc = 0; rk = 0; didx = 0; fid = f;
    cur_ferr = fe;
    cur_sw = (32'(f) << 20) | (32'(fe) << 16) | 32'(len * 4);
  endtask

  function automatic logic [34:0] fw(int i, int len, bit we);
    return {we, i == 0, i == len - 1, wd(fid, i)};
  endfunction

  task automatic run_frame(int cfg, int lim, int len, int f, bit fe, bit werr, bit serr);
    int tgt, d0;
    setup(cfg, lim, len, f, fe);
    d0 = data_n;
    for (int i = 0; i < len; i++) q.push_back(fw(i, len, werr && i == 1));
    q.push_back({3'b000, cur_sw});
    err_once = serr;
    tgt = wb_n + ndesc;
    nv = 1;
    while (wb_n < tgt) cycle();
    repeat (3) cycle();
    chk(q.size() == 0, "R7 status consumed", 32'(q.size()), 0);
    chk(data_n - d0 == len, "R3 word count", 32'(data_n - d0), 32'(len));
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int m0, c0, d0;
    foreach (mem[i]) mem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(m_cmd == 0, "R1 reset command", 32'(m_cmd), 0);
    chk(!fifo_rd && !miss_inc && !ds_done, "R1 reset strobes", {fifo_rd, miss_inc, ds_done}, 0);
    rst_n = 1;
    repeat (2) cycle();

    for (int cfg = 0; cfg < 3; cfg++)
      for (int li = 0; li < 5; li++)
        for (int len = 1; len <= 10; len++)
          run_frame(cfg, (li == 4) ? 0 : ((li == 3) ? 4 : li + 1), len, (cfg * 50 + li * 10 + len) & 255, 0, 0, 0);

    run_frame(1, 4, 6, 200, 1, 0, 0);
    run_frame(1, 2, 5, 201, 0, 1, 0);
    run_frame(0, 3, 8, 202, 0, 0, 1);
    run_frame(2, 1, 6, 203, 0, 0, 1);

    m0 = miss_n; c0 = cmd_n;
    setup(1, 4, 3, 210, 0);
    nv = 0;
    for (int i = 0; i < 3; i++) q.push_back(fw(i, 3, 0));
    q.push_back({3'b000, cur_sw});
    repeat (12) cycle();
    chk(miss_n - m0 == 1, "R8 miss pulse", 32'(miss_n - m0), 1);
    chk(q.size() == 0, "R8 frame discarded", 32'(q.size()), 0);
    chk(cmd_n == c0, "R8 no bus use", 32'(cmd_n - c0), 0);

    m0 = miss_n; d0 = data_n;
    setup(1, 4, 3, 211, 0);
    for (int i = 0; i < 3; i++) q.push_back(fw(i, 3, 0));
    q.push_back({3'b000, cur_sw});
    drop = 1; nv = 1;
    repeat (30) cycle();
    drop = 0;
    chk(data_n == d0, "R4 no write after drop", 32'(data_n - d0), 0);
    chk(miss_n - m0 == 1, "R4 idle discards frame", 32'(miss_n - m0), 1);
    chk(q.size() == 0, "R4 fifo drained", 32'(q.size()), 0);

    d0 = data_n;
    setup(1, 4, 5, 220, 0);
    chk_burst = 0; trickle = 1; nv = 1;
    for (int i = 0; i < 5; i++) begin
      q.push_back(fw(i, 5, 0));
      repeat (8) cycle();
    end
    trickle = 0;
    q.push_back({3'b000, cur_sw});
    c0 = wb_n + 1;
    while (wb_n < c0) cycle();
    chk_burst = 1;
    chk(data_n - d0 == 5, "R6 trickle words", 32'(data_n - d0), 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule